// File: doc/BRIEF.md
# Refresh-Safe DRAM Write-Enable Guard

This block sits between an older host memory controller and newer, denser asynchronous DRAM devices. The host drives active-low row strobe, column strobe and write-enable lines. It issues only three kinds of cycle: a normal read, an early write, and a refresh in which the column strobe goes low before the row strobe. The denser devices read a low write-enable at the falling row strobe of such a refresh as a request to enter a test mode. The host leaves write-enable at whatever level the previous access used, so a refresh that follows a write would corrupt memory. The guard classifies every cycle and forces write-enable high towards the memory whenever a refresh is about to start or is running. In all other cycles it passes the host's write-enable through with no added latency.

The guard also produces the two upper DRAM address bits from the host's two row-select lines. While the row strobe is high, these bits follow the row selects. From the falling row strobe until the row strobe rises again, they hold the last row-phase value. The strobes are sampled by a free-running clock that runs much faster than the strobe edges. The write-enable and address outputs are combinational from the current inputs and a small amount of registered cycle state. All control pins are plain levels: no data stream crosses this block, so it has no valid/ready handshake.

Top module: `dre_refresh_we_guard`

## Requirements
- R1: After reset, with both strobes high, mem_we_n equals host_we_n and mem_addr_hi equals host_rowsel in the same cycle.
- R2: In a read or write cycle (row strobe sampled falling while the column strobe is high), mem_we_n equals host_we_n at every sample while the row strobe stays low, with no cycle of latency.
- R3: Whenever the column strobe is low while the row strobe is high, mem_we_n is 1, whatever host_we_n is.
- R4: Once a refresh starts (row strobe sampled falling with the column strobe low), mem_we_n stays 1 at every sample until the row strobe is sampled high again, even if the column strobe rises or host_we_n toggles.
- R5: With both strobes high, mem_we_n equals host_we_n, including the first sample after a refresh ends.
- R6: At the sample where the row strobe is first seen low (the previous sample saw it high) and the column strobe is low, mem_we_n is 1.
- R7: While the row strobe is high, mem_addr_hi[0] equals host_rowsel[0] and mem_addr_hi[1] equals host_rowsel[1].
- R8: While the row strobe is low, mem_addr_hi holds the host_rowsel value sampled at the last clock edge that saw the row strobe high, and changes on host_rowsel have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the strobe edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ras_n | input | 1 | Host row strobe, active low |
| host_cas_n | input | 1 | Host column strobe, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| host_rowsel | input | ADDR_HI_W | Host row-select lines that map to the upper address bits |
| mem_we_n | output | 1 | Guarded write-enable towards the DRAM |
| mem_addr_hi | output | ADDR_HI_W | Upper DRAM address bits 10 and up |

## Verification
The bench mainly targets a refresh that directly follows a write with host_we_n still low. A guard that reacts only after its registered state updates would let a low write-enable reach the DRAM at the falling row strobe, which selects test mode. The bench also ends refreshes with the column strobe released first and then the row strobe. A guard that drops the override on the column strobe would pass a stale low mid-refresh, and one that clears late would block the first write after the refresh. An exhaustive sweep over every pair of consecutive input vectors exposes any added latency on the pass-through path. It also exposes upper-address bits that follow row selects changed during the row-low phase.

// File: rtl/dre_guard_pkg.sv
package dre_guard_pkg;

  // Cycle class recorded at the falling row strobe.
  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ACCESS  = 2'd1,
    CYC_REFRESH = 2'd2
  } dre_cycle_e;

  // Upper address bit index of the first derived line on the DRAM.
  localparam int unsigned DRE_ADDR_HI_BASE = 10;

endpackage

// File: rtl/dre_cycle_classifier.sv
module dre_cycle_classifier
  import dre_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       cas_n,
  output dre_cycle_e cycle,
  output logic       ras_fall_now
);

  logic       ras_q;
  dre_cycle_e cycle_q;
  dre_cycle_e cycle_d;

  // Row strobe was high at the last edge and is low now.
  assign ras_fall_now = ras_q & ~ras_n;

  always_comb begin
    cycle_d = cycle_q;
    if (ras_n) begin
      cycle_d = CYC_IDLE;
    end else if (ras_fall_now) begin
      cycle_d = cas_n ? CYC_ACCESS : CYC_REFRESH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q   <= 1'b1;
      cycle_q <= CYC_IDLE;
    end else begin
      ras_q   <= ras_n;
      cycle_q <= cycle_d;
    end
  end

  assign cycle = cycle_q;

endmodule

// File: rtl/dre_we_gate.sv
module dre_we_gate
  import dre_guard_pkg::*;
(
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n_in,
  input  dre_cycle_e cycle,
  input  logic       ras_fall_now,
  output logic       we_n_out
);

  logic pre_ras_cbr;
  logic fall_cbr;
  logic in_refresh;
  logic force_high;

  // Column strobe leads the row strobe: a refresh is being set up.
  assign pre_ras_cbr = ~cas_n & ras_n;
  // Row strobe falls in this sample with the column strobe low.
  assign fall_cbr    = ~cas_n & ras_fall_now;
  // Registered refresh state, valid until the row strobe rises.
  assign in_refresh  = (cycle == CYC_REFRESH) & ~ras_n;

  assign force_high = pre_ras_cbr | fall_cbr | in_refresh;
  assign we_n_out   = force_high | we_n_in;

endmodule

// File: rtl/dre_row_addr.sv
module dre_row_addr #(
  parameter int unsigned ADDR_HI_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras_n,
  input  logic [ADDR_HI_W-1:0] rowsel,
  output logic [ADDR_HI_W-1:0] addr_hi
);

  for (genvar b = 0; b < ADDR_HI_W; b++) begin : g_bit
    logic held_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held_q <= 1'b0;
      end else if (ras_n) begin
        held_q <= rowsel[b];
      end
    end

    assign addr_hi[b] = ras_n ? rowsel[b] : held_q;
  end

endmodule

// File: rtl/dre_refresh_we_guard.sv
module dre_refresh_we_guard
  import dre_guard_pkg::*;
#(
  parameter int unsigned ADDR_HI_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_ras_n,
  input  logic                 host_cas_n,
  input  logic                 host_we_n,
  input  logic [ADDR_HI_W-1:0] host_rowsel,
  output logic                 mem_we_n,
  output logic [ADDR_HI_W-1:0] mem_addr_hi
);

  dre_cycle_e cycle;
  logic       ras_fall_now;

  dre_cycle_classifier u_class (
    .clk          (clk),
    .rst_n        (rst_n),
    .ras_n        (host_ras_n),
    .cas_n        (host_cas_n),
    .cycle        (cycle),
    .ras_fall_now (ras_fall_now)
  );

  dre_we_gate u_gate (
    .ras_n        (host_ras_n),
    .cas_n        (host_cas_n),
    .we_n_in      (host_we_n),
    .cycle        (cycle),
    .ras_fall_now (ras_fall_now),
    .we_n_out     (mem_we_n)
  );

  dre_row_addr #(
    .ADDR_HI_W (ADDR_HI_W)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_n   (host_ras_n),
    .rowsel  (host_rowsel),
    .addr_hi (mem_addr_hi)
  );

endmodule

// File: rtl/dre_guard_checker.sv
module dre_guard_checker #(
  parameter int unsigned ADDR_HI_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 host_ras_n,
  input logic                 host_cas_n,
  input logic                 host_we_n,
  input logic [ADDR_HI_W-1:0] host_rowsel,
  input logic                 mem_we_n,
  input logic [ADDR_HI_W-1:0] mem_addr_hi
);

  logic chk_ras_q;
  logic chk_refresh;
  logic chk_access;
  logic chk_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_ras_q   <= 1'b1;
      chk_refresh <= 1'b0;
      chk_access  <= 1'b0;
      chk_armed   <= 1'b0;
    end else begin
      chk_ras_q <= host_ras_n;
      chk_armed <= 1'b1;
      if (host_ras_n) begin
        chk_refresh <= 1'b0;
        chk_access  <= 1'b0;
      end else if (chk_ras_q) begin
        chk_refresh <= ~host_cas_n;
        chk_access  <= host_cas_n;
      end
    end
  end

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ras_n && host_cas_n) |-> (mem_we_n == host_we_n)); // R5
  AST_ACCESS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ras_n && !chk_ras_q && chk_access) |-> (mem_we_n == host_we_n)); // R2
  AST_PRE_RAS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ras_n && !host_cas_n) |-> mem_we_n); // R3
  AST_REFRESH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ras_n && chk_refresh) |-> mem_we_n); // R4
  AST_CBR_EDGE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ras_n && chk_ras_q && !host_cas_n) |-> mem_we_n); // R6
  AST_ROW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    host_ras_n |-> (mem_addr_hi == host_rowsel)); // R7
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && !host_ras_n && !chk_ras_q) |-> $stable(mem_addr_hi)); // R8

endmodule

bind dre_refresh_we_guard dre_guard_checker #(
  .ADDR_HI_W (ADDR_HI_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_ras_n  (host_ras_n),
  .host_cas_n  (host_cas_n),
  .host_we_n   (host_we_n),
  .host_rowsel (host_rowsel),
  .mem_we_n    (mem_we_n),
  .mem_addr_hi (mem_addr_hi)
);

// File: tb/dre_refresh_we_guard_bench.sv
module dre_refresh_we_guard_bench;

  localparam int unsigned W = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ras_n = 1'b1;
  logic         cas_n = 1'b1;
  logic         we_n = 1'b1;
  logic [W-1:0] rs = '0;
  logic         mwe;
  logic [W-1:0] maddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model state, built from the requirements.
  logic         m_ras_q = 1'b1;
  logic         m_refresh = 1'b0;
  logic [W-1:0] m_held = '0;

  always #10 clk = ~clk;

  dre_refresh_we_guard #(.ADDR_HI_W(W)) u_dre_refresh_we_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ras_n  (ras_n),
    .host_cas_n  (cas_n),
    .host_we_n   (we_n),
    .host_rowsel (rs),
    .mem_we_n    (mwe),
    .mem_addr_hi (maddr)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one sample, check outputs before the edge, then advance the model.
  task automatic step(input logic r, input logic c, input logic w, input logic [W-1:0] s);
    logic  exp_we;
    string tag_we;
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; rs = s;
    #5;
    if (r && c) begin
      exp_we = w; tag_we = "R5";
    end else if (r && !c) begin
      exp_we = 1'b1; tag_we = "R3";
    end else if (m_ras_q && !c) begin
      exp_we = 1'b1; tag_we = "R6";
    end else if (!m_ras_q && m_refresh) begin
      exp_we = 1'b1; tag_we = "R4";
    end else begin
      exp_we = w; tag_we = "R2";
    end
    check(tag_we, {{(W-1){1'b0}}, mwe}, {{(W-1){1'b0}}, exp_we});
    if (r) check("R7", maddr, s);
    else   check("R8", maddr, m_held);
    @(posedge clk);
    if (r) begin
      m_refresh = 1'b0;
      m_held    = s;
    end else if (m_ras_q) begin
      m_refresh = ~c;
    end
    m_ras_q = r;
  endtask

  task automatic rd_wr_cycle(input logic w, input logic [W-1:0] s);
    step(1, 1, w, s);
    step(0, 1, w, s);
    step(0, 0, w, ~s);
    step(0, 0, w, ~s);
    step(1, 1, w, s);
  endtask

  task automatic refresh_cycle(input logic w, input logic [W-1:0] s);
    step(1, 0, w, s);
    step(0, 0, w, s);
    step(0, 0, ~w, ~s);
    step(0, 1, w, s);
    step(1, 1, w, s);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    // R1: reset state, both strobes high.
    @(negedge clk);
    we_n = 1'b0; rs = 2'b10;
    #5;
    check("R1", {1'b0, mwe}, 2'b00);
    check("R1", maddr, 2'b10);
    @(posedge clk);
    m_held = 2'b10;
    // Directed: write with WE low, then refresh with WE left low.
    for (int s = 0; s < 4; s++) begin
      rd_wr_cycle(1'b0, W'(s));
      refresh_cycle(1'b0, W'(s));
      rd_wr_cycle(1'b1, W'(s));
      refresh_cycle(1'b1, W'(s));
      rd_wr_cycle(1'b0, W'(s));
    end
    // Exhaustive sweep over pairs of consecutive input vectors.
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        step(a[4], a[3], a[2], a[1:0]);
        step(b[4], b[3], b[2], b[1:0]);
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule